// File: doc/BRIEF.md
# GPIO Pin Control with Interrupt Detection

A port of up to 32 general-purpose pins, each governed by its own control register, plus one parallel output register and one parallel input register. All registers sit behind a simple single-cycle request bus: writes land at the clock edge, and read data appears on `rdata_o` one cycle after the request. Each implemented pin drives a pad output and an output-enable, requests a pull-up or pull-down, and raises an interrupt source bit that a separate interrupt aggregator consumes.

Output ownership is explicit. A pin's parallel output bit accepts writes only while that pin's software-ownership bit is set. Otherwise the pad value comes from an alternate-function source, modelled here as a plain input bit. Software can therefore preload the output value while the pin is still an input, and then flip the direction bit to drive the pad with no glitch.

Pad inputs pass through a two-flop synchroniser. They are then gated by the power-off and input-disable controls, and fed to a per-pin detector with level and edge modes. The detector has an explicit disable code, because the all-zero code selects level-low. After any change of detection mode, edge reports are blanked for a short settling window.

Top module: `gpio_pinctl`

## Requirements
- R1: The word address of a pin's control register equals its pin number. The control register reads back what was written, with bit 7 always 0. After reset it reads 0x400. Its fields are: bit 0 direction (1 = output); bits 2:1 pull select; bit 3 buffer type (1 = open-drain); bit 4 power off; bit 5 input disable; bit 6 software ownership of the output; bits 11:8 detection mode. The read comes back one cycle after the request.
- R2: For a pin outside VALID_MASK:
  - writes to its control register are ignored and its control register reads 0;
  - its parallel-input bit reads 0;
  - its pad output-enable, pull requests and interrupt source all stay 0.
- R3: The parallel output register is at word address NPINS. A write updates only the bits of valid pins whose ownership bit (control bit 6) is 1; every other bit keeps its value. It resets to 0.
- R4: The pad output value is the parallel output bit when the ownership bit is 1, and `alt_out_i` when the ownership bit is 0.
- R5: The pad output-enable is 0 whenever the direction bit is 0. A value preloaded into the parallel output register reaches the pad only once the direction bit becomes 1.
- R6: In push-pull mode (bit 3 = 0), an output pin has the enable set and drives the value. In open-drain mode (bit 3 = 1), `pad_out_o` is 0 and the enable is set only while the value is 0.
- R7: Pull select 01 raises `pad_pu_o`. Pull select 10 raises `pad_pd_o`. Codes 00 and 11 raise neither.
- R8: While power off (bit 4) or input disable (bit 5) is set, the pin's parallel-input bit reads 0 and its interrupt source stays 0.
- R9: The parallel input register is at word address NPINS+1. It returns the gated pad input levels, which reflect a pad change two clock edges after it.
- R10: The level modes are 0000 (level-low) and 0001 (level-high). In these modes the interrupt source is high for as long as the synchronised level matches.
- R11: The edge modes are 1101 (rising), 1110 (falling) and 1111 (both). Each qualifying transition gives a pulse on the interrupt source exactly one cycle wide.
- R12: A control write that changes the detection mode suppresses edge reports for the 4 cycles after that write.
- R13: Mode 0100 (disabled) and every unlisted code never raise the interrupt source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 6 | Word address: pins 0..NPINS-1, NPINS = parallel output, NPINS+1 = parallel input |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the request |
| alt_out_i | input | 32 | Alternate-function output value per pin |
| pad_in_i | input | 32 | Asynchronous pad input levels |
| pad_out_o | output | 32 | Pad output value |
| pad_oe_o | output | 32 | Pad output enable |
| pad_pu_o | output | 32 | Pull-up request |
| pad_pd_o | output | 32 | Pull-down request |
| irq_src_o | output | 32 | Per-pin interrupt source to the aggregator |

## Verification
The errors that matter are ones inside the block: a stale control or ownership bit, a wrongly loaded blanking counter, or a detector register that is out of step with the input level. Each one shows up at the ports within a few cycles:
- a corrupted control field appears in the next readback and at once on the pad enable or pull outputs;
- a parallel output bit that was wrongly written shows on `pad_out_o` in the same cycle the pin drives;
- a bad edge history or blanking count produces a missing, doubled or premature `irq_src_o` pulse two to three cycles after the pad transition.

// File: rtl/gpio_pinctl_pkg.sv
package gpio_pinctl_pkg;
  localparam int CTRL_W = 12;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 12'hF7F;
  localparam logic [CTRL_W-1:0] CTRL_RST   = 12'h400;

  typedef enum logic [3:0] {
    DET_LVL_LO = 4'b0000,
    DET_LVL_HI = 4'b0001,
    DET_OFF    = 4'b0100,
    DET_RISE   = 4'b1101,
    DET_FALL   = 4'b1110,
    DET_BOTH   = 4'b1111
  } det_mode_e;

  typedef struct packed {
    logic [3:0] det;
    logic       rsvd;
    logic       sw_own;
    logic       in_dis;
    logic       pwr_off;
    logic       od;
    logic [1:0] pull;
    logic       dir;
  } pin_ctrl_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_pinctl_pkg::*;
#(
  parameter int BLANK_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       lvl_i,
  input  logic [3:0] mode_i,
  input  logic       mode_chg_i,
  output logic       irq_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic          prev_q;
  logic [BW-1:0] blank_q;
  logic          rise, fall, edge_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      blank_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (mode_chg_i)        blank_q <= BW'(BLANK_CYC);
      else if (blank_q != 0) blank_q <= blank_q - 1'b1;
    end
  end

  assign rise    = lvl_i & ~prev_q;
  assign fall    = ~lvl_i & prev_q;
  assign edge_ok = en_i && (blank_q == 0);

  always_comb begin
    case (mode_i)
      DET_LVL_LO: irq_o = en_i & ~lvl_i;
      DET_LVL_HI: irq_o = en_i & lvl_i;
      DET_RISE:   irq_o = edge_ok & rise;
      DET_FALL:   irq_o = edge_ok & fall;
      DET_BOTH:   irq_o = edge_ok & (rise | fall);
      default:    irq_o = 1'b0;
    endcase
  end

  AST_EDGE_BLANKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_q != 0 && mode_i[3]) |-> !irq_o); // R12
  AST_RISE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DET_RISE && irq_o) |=> (mode_i != DET_RISE || !irq_o)); // R11
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == DET_OFF) |-> !irq_o); // R13
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pinctl_pkg::*;
#(
  parameter int BLANK_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wd_i,
  input  logic              pout_we_i,
  input  logic              pout_d_i,
  input  logic              alt_out_i,
  input  logic              pad_in_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              pout_o,
  output logic              lvl_o,
  output logic              irq_o,
  output logic              pad_out_o,
  output logic              pad_oe_o,
  output logic              pad_pu_o,
  output logic              pad_pd_o
);
  pin_ctrl_t ctrl_q;
  logic      pout_q, sync_lvl, en, val;
  logic      mode_chg;
  logic [CTRL_W-1:0] wd_m;

  assign wd_m     = ctrl_wd_i & CTRL_WMASK;
  assign mode_chg = ctrl_we_i && (wd_m[CTRL_W-1 -: 4] != ctrl_q.det);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= pin_ctrl_t'(CTRL_RST);
      pout_q <= 1'b0;
    end else begin
      if (ctrl_we_i)                pout_q <= pout_q;
      if (ctrl_we_i)                ctrl_q <= pin_ctrl_t'(wd_m);
      if (pout_we_i && ctrl_q.sw_own) pout_q <= pout_d_i;
    end
  end

  gpio_sync2 #(.W(1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (sync_lvl)
  );

  assign en    = ~ctrl_q.pwr_off & ~ctrl_q.in_dis;
  assign lvl_o = sync_lvl & en;

  gpio_irq_detect #(.BLANK_CYC(BLANK_CYC)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .lvl_i     (lvl_o),
    .mode_i    (ctrl_q.det),
    .mode_chg_i(mode_chg),
    .irq_o     (irq_o)
  );

  // ownership picks the output source; open-drain only ever pulls low
  assign val       = ctrl_q.sw_own ? pout_q : alt_out_i;
  assign pad_out_o = ctrl_q.od ? 1'b0 : val;
  assign pad_oe_o  = ctrl_q.dir & (ctrl_q.od ? ~val : 1'b1);
  assign pad_pu_o  = (ctrl_q.pull == 2'b01);
  assign pad_pd_o  = (ctrl_q.pull == 2'b10);
  assign ctrl_o    = ctrl_q;
  assign pout_o    = pout_q;

  AST_POUT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pout_we_i && !ctrl_q.sw_own) |=> $stable(pout_q)); // R3
  AST_OE_NEEDS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_oe_o |-> ctrl_q.dir); // R5
  AST_IN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.pwr_off || ctrl_q.in_dis) |-> (!lvl_o && !irq_o)); // R8
  AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.od && pad_oe_o) |-> !pad_out_o); // R6
endmodule

// File: rtl/gpio_pinctl.sv
module gpio_pinctl
  import gpio_pinctl_pkg::*;
#(
  parameter int               NPINS      = 32,
  parameter int               DATA_W     = 32,
  parameter int               BLANK_CYC  = 4,
  parameter logic [NPINS-1:0] VALID_MASK = 32'h7FFF_7FFF,
  localparam int              ADDR_W     = $clog2(NPINS + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  alt_out_i,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic [NPINS-1:0]  pad_pu_o,
  output logic [NPINS-1:0]  pad_pd_o,
  output logic [NPINS-1:0]  irq_src_o
);
  localparam logic [ADDR_W-1:0] A_POUT = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(NPINS + 1);

  logic [CTRL_W-1:0] ctrl_rd [NPINS];
  logic [NPINS-1:0]  pout_vec, lvl_vec;
  logic              pout_we;
  logic [DATA_W-1:0] rd_d, rdata_q;

  assign pout_we = req_i && we_i && (addr_i == A_POUT);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (VALID_MASK[i]) begin : g_on
      gpio_pin_cell #(.BLANK_CYC(BLANK_CYC)) u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ctrl_we_i(req_i && we_i && (addr_i == ADDR_W'(i))),
        .ctrl_wd_i(wdata_i[CTRL_W-1:0]),
        .pout_we_i(pout_we),
        .pout_d_i (wdata_i[i]),
        .alt_out_i(alt_out_i[i]),
        .pad_in_i (pad_in_i[i]),
        .ctrl_o   (ctrl_rd[i]),
        .pout_o   (pout_vec[i]),
        .lvl_o    (lvl_vec[i]),
        .irq_o    (irq_src_o[i]),
        .pad_out_o(pad_out_o[i]),
        .pad_oe_o (pad_oe_o[i]),
        .pad_pu_o (pad_pu_o[i]),
        .pad_pd_o (pad_pd_o[i])
      );
    end else begin : g_off
      assign ctrl_rd[i]   = '0;
      assign pout_vec[i]  = 1'b0;
      assign lvl_vec[i]   = 1'b0;
      assign irq_src_o[i] = 1'b0;
      assign pad_out_o[i] = 1'b0;
      assign pad_oe_o[i]  = 1'b0;
      assign pad_pu_o[i]  = 1'b0;
      assign pad_pd_o[i]  = 1'b0;
    end
  end

  always_comb begin
    rd_d = '0;
    if (addr_i == A_POUT)     rd_d = DATA_W'(pout_vec);
    else if (addr_i == A_PIN) rd_d = DATA_W'(lvl_vec);
    else
      for (int i = 0; i < NPINS; i++)
        if (addr_i == ADDR_W'(i)) rd_d = DATA_W'(ctrl_rd[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;

  AST_INVALID_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_src_o | pad_oe_o | pad_pu_o | pad_pd_o) & ~VALID_MASK) == '0); // R2
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R1
endmodule

// File: tb/gpio_pinctl_tb_top.sv
module gpio_pinctl_tb_top;
  localparam int          NP         = 32;
  localparam int          AW         = 6;
  localparam logic [31:0] VM         = 32'h7FFF_7FFF;
  localparam int          CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] alt_out = '0, pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd, irq;

  int n_cmp = 0, n_bad = 0;
  logic [11:0] m_ctrl [NP];
  logic [31:0] m_pout = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pinctl #(.NPINS(NP), .DATA_W(32), .BLANK_CYC(4), .VALID_MASK(VM)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .alt_out_i(alt_out), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu),
    .pad_pd_o(pad_pd), .irq_src_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] own_mask();
    logic [31:0] m = '0;
    for (int i = 0; i < NP; i++) m[i] = m_ctrl[i][6];
    return m;
  endfunction

  function automatic logic [31:0] gate_ok();
    logic [31:0] m = '0;
    for (int i = 0; i < NP; i++) m[i] = VM[i] & ~m_ctrl[i][4] & ~m_ctrl[i][5];
    return m;
  endfunction

  function automatic void model_wr(int a, logic [31:0] d);
    logic [31:0] om;
    if (a < NP) begin
      if (VM[a]) m_ctrl[a] = d[11:0] & 12'hF7F;
    end else if (a == NP) begin
      om = own_mask() & VM;
      m_pout = (m_pout & ~om) | (d & om);
    end
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic chk_pads(string tag);
    logic [31:0] e_out, e_oe, e_pu, e_pd;
    logic v;
    e_out = '0; e_oe = '0; e_pu = '0; e_pd = '0;
    for (int i = 0; i < NP; i++) begin
      if (VM[i]) begin
        v = m_ctrl[i][6] ? m_pout[i] : alt_out[i];
        e_out[i] = m_ctrl[i][3] ? 1'b0 : v;
        e_oe[i]  = m_ctrl[i][0] & (m_ctrl[i][3] ? ~v : 1'b1);
        e_pu[i]  = (m_ctrl[i][2:1] == 2'b01);
        e_pd[i]  = (m_ctrl[i][2:1] == 2'b10);
      end
    end
    chk({tag, " R4/R6 pad_out"}, pad_out, e_out);
    chk({tag, " R5/R6 pad_oe"}, pad_oe, e_oe);
    chk({tag, " R7 pad_pu"}, pad_pu, e_pu);
    chk({tag, " R7 pad_pd"}, pad_pd, e_pd);
  endtask

  task automatic count_irq(int pin, int ncyc, output int cnt);
    cnt = 0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      if (irq[pin]) cnt++;
    end
  endtask

  // settle pad, change level, count pulses on pin 3
  task automatic edge_case(string tag, logic [3:0] mode, int e_up, int e_dn);
    int c;
    pad_in[3] = 1'b0;
    wr(3, {20'h0, mode, 8'h00});
    repeat (8) @(negedge clk);
    pad_in[3] = 1'b1;
    count_irq(3, 6, c);
    chk({tag, " rise"}, c, e_up);
    pad_in[3] = 1'b0;
    count_irq(3, 6, c);
    chk({tag, " fall"}, c, e_dn);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r, d, e;
    int c, pin;
    for (int i = 0; i < NP; i++) m_ctrl[i] = VM[i] ? 12'h400 : 12'h000;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // reset state
    rd(0, r);  chk("R1 reset ctrl", r, 32'h400);
    rd(NP, r); chk("R3 reset pout", r, 32'h0);
    chk("R13 reset irq quiet", irq, 32'h0);
    chk("R5 reset oe", pad_oe, 32'h0);

    // R2: invalid pin 15
    wr(15, 32'h0000_0147);
    rd(15, r); chk("R2 invalid ctrl read", r, 32'h0);
    pad_in[15] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 invalid irq", {31'h0, irq[15]}, 32'h0);
    chk("R2 invalid oe", {31'h0, pad_oe[15]}, 32'h0);
    rd(NP + 1, r); chk("R2 invalid pin input", {31'h0, r[15]}, 32'h0);
    pad_in[15] = 1'b0;

    // R3/R5: preload while input, then drive
    wr(6, 32'h0000_0440);            // own=1 dir=0
    wr(NP, 32'h0000_0040);
    chk("R5 preload not driven", {31'h0, pad_oe[6]}, 32'h0);
    wr(6, 32'h0000_0441);            // dir=1
    chk("R5 drive after dir", {30'h0, pad_oe[6], pad_out[6]}, 32'h3);
    wr(6, 32'h0000_0401);            // own=0
    wr(NP, 32'h0);
    rd(NP, r); chk("R3 write ignored without ownership", {31'h0, r[6]}, 32'h1);

    // R4: alternate source
    alt_out[6] = 1'b1; #1;
    chk("R4 alt high", {31'h0, pad_out[6]}, 32'h1);
    alt_out[6] = 1'b0; #1;
    chk("R4 alt low", {31'h0, pad_out[6]}, 32'h0);

    // R10 level modes
    pad_in[3] = 1'b1;
    wr(3, 32'h0000_0100);
    repeat (3) @(negedge clk);
    count_irq(3, 4, c); chk("R10 level-high steady", c, 4);
    pad_in[3] = 1'b0;
    wr(3, 32'h0000_0000);
    repeat (3) @(negedge clk);
    count_irq(3, 4, c); chk("R10 level-low steady", c, 4);

    // R11 edges
    edge_case("R11 rising", 4'b1101, 1, 0);
    edge_case("R11 falling", 4'b1110, 0, 1);
    edge_case("R11 both", 4'b1111, 1, 1);
    // R13 disabled and unlisted codes
    edge_case("R13 disabled", 4'b0100, 0, 0);
    edge_case("R13 unlisted", 4'b0110, 0, 0);

    // R8 gating
    pad_in[3] = 1'b1;
    wr(3, 32'h0000_0110);            // level-high, power off
    repeat (3) @(negedge clk);
    chk("R8 power off irq", {31'h0, irq[3]}, 32'h0);
    rd(NP + 1, r); chk("R8 power off input", {31'h0, r[3]}, 32'h0);
    wr(3, 32'h0000_0120);            // input disable
    repeat (3) @(negedge clk);
    chk("R8 input disable irq", {31'h0, irq[3]}, 32'h0);
    wr(3, 32'h0000_0100);
    repeat (3) @(negedge clk);
    chk("R8 ungated irq", {31'h0, irq[3]}, 32'h1);

    // R12 blanking: mode change with a simultaneous edge
    wr(3, 32'h0000_0E00);
    repeat (8) @(negedge clk);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = AW'(3); wdata = 32'h0000_0F00;
    pad_in[3] = 1'b0;
    @(negedge clk);
    req = 1'b0; we = 1'b0; model_wr(3, 32'h0000_0F00);
    count_irq(3, 6, c); chk("R12 edge blanked", c, 0);
    pad_in[3] = 1'b1;
    count_irq(3, 6, c); chk("R12 edge after window", c, 1);

    // random sweep: R1 R3 R4 R5 R6 R7 R9
    for (int it = 0; it < 150; it++) begin
      pin = int'($urandom % NP);
      d = $urandom;
      wr(pin, d);
      rd(pin, r);
      chk("R1 ctrl readback", r, {20'h0, m_ctrl[pin]});
      wr(NP, $urandom);
      rd(NP, r);
      chk("R3 pout readback", r, m_pout & VM);
      alt_out = $urandom;
      pad_in = $urandom;
      repeat (3) @(negedge clk);
      chk_pads("rand");
      rd(NP + 1, r);
      e = pad_in & gate_ok();
      chk("R9 parallel input", r, e);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule